// File: doc/BRIEF.md
# Dual Carrier Symbol Mapper

This block sits in an OFDM transmit path between the bit interleaver and the inverse FFT. It turns a frame of interleaved coded bits into a sequential stream of 16-point constellation symbols. The frame holds several equal blocks. From each block the mapper collects four-bit groups with a split index rule. Every group is turned into two complex symbols, one for the lower half of the block's symbol stream and one for the upper half. The lower half leaves the block as it is computed. The matching upper-half symbols go into a small internal buffer and are replayed right after the lower half, so each block appears as one ordered stream of symbol indices 0 up to 2·HALF−1.

A single start pulse, sampled while the mapper is idle, captures the whole frame from a wide input vector. The mapper then walks through every block. It spends one preparation cycle plus 2·HALF output cycles on each block, and it flags the last symbol of the frame with a done strobe. With the defaults (HALF = 50, BLOCKS = 6) a frame is 1200 bits, each block is 200 bits, and each block yields 100 symbols in 101 cycles.

Top module: `dcm_mapper`

## Requirements
- R1: In block j, bit i is frame_i[j·4·HALF + i]. Group k (0 ≤ k < HALF) starts at position g = 2k when k < HALF/2 and at g = 2k + HALF otherwise. Its nibble is v = {b[g], b[g+1], b[g+HALF], b[g+HALF+1]}, with v[3] the first bit.
- R2: Symbol k (the lower half) has I given by v[3:2] and Q given by v[1:0], with 00→−3, 01→−1, 10→+1 and 11→+3. Values are 4-bit two's complement (−3 = 4'hD, −1 = 4'hF, +1 = 4'h1, +3 = 4'h3).
- R3: Symbol k+HALF (the upper half) uses the same encoding, but the pair 00→+1, 01→−3, 10→+3, 11→−1 is applied to v[3:2] for I and to v[1:0] for Q.
- R4: Within a block, sym_valid_o stays high for exactly 2·HALF consecutive cycles while sym_idx_o counts 0, 1, … 2·HALF−1. Indices below HALF carry lower-half symbols and the rest carry upper-half symbols.
- R5: The first valid symbol appears two cycles after the clock edge that samples start_i. Exactly one invalid cycle separates consecutive blocks, which makes 2·HALF+1 cycles per block.
- R6: One start produces BLOCKS blocks in ascending block order, and then the mapper returns to idle.
- R7: done_o is high for a single cycle, together with the final symbol (index 2·HALF−1) of the final block.
- R8: start_i is ignored while a frame is being mapped. The frame is captured when start is accepted, so later changes on frame_i do not alter the symbols of the running frame.
- R9: During reset, and in any cycle where sym_valid_o is low, sym_i_o, sym_q_o and sym_idx_o read zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| frame_i | input | BLOCKS·4·HALF | Frame of interleaved bits, captured on start |
| sym_valid_o | output | 1 | Symbol strobe |
| sym_i_o | output | 4 | In-phase level, two's complement |
| sym_q_o | output | 4 | Quadrature level, two's complement |
| sym_idx_o | output | clog2(2·HALF) | Symbol index within the current block |
| done_o | output | 1 | Marks the last symbol of the frame |

## Verification
The bench builds two copies of the block at the default sizes: HALF = 50 and BLOCKS = 6. One copy uses the table form of the level mapping and the other uses the reduced gate equations, so any disagreement between the two variants shows up symbol by symbol. The full-size frame puts the group-index split at k = 25 within reach, along with the far bit positions up to 199 in each block and the replay of all 50 buffer entries. A directed frame that walks every nibble value through each block covers all 16 entries of both halves of the mapping table.

// File: rtl/dcm_map_pkg.sv
package dcm_map_pkg;

   localparam int LEVEL_W = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PREP  = 2'd1,
      ST_FRONT = 2'd2,
      ST_BACK  = 2'd3
   } map_state_e;

   typedef struct packed {
      logic [LEVEL_W-1:0] re;
      logic [LEVEL_W-1:0] im;
   } sym_t;

   // level for the lower-half symbol of a group
   function automatic logic [LEVEL_W-1:0] lower_level(input logic [1:0] pair);
      case (pair)
         2'b00:   lower_level = 4'hD;
         2'b01:   lower_level = 4'hF;
         2'b10:   lower_level = 4'h1;
         default: lower_level = 4'h3;
      endcase
   endfunction

   // level for the upper-half symbol of a group
   function automatic logic [LEVEL_W-1:0] upper_level(input logic [1:0] pair);
      case (pair)
         2'b00:   upper_level = 4'h1;
         2'b01:   upper_level = 4'hD;
         2'b10:   upper_level = 4'h3;
         default: upper_level = 4'hF;
      endcase
   endfunction

endpackage

// File: rtl/dcm_map_ctrl.sv
module dcm_map_ctrl
   import dcm_map_pkg::*;
#(
   parameter int HALF   = 50,
   parameter int BLOCKS = 6,
   localparam int SYMS  = 2 * HALF,
   localparam int CNT_W = $clog2(SYMS),
   localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output map_state_e       state_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [BLK_W-1:0] blk_o,
   output logic             accept_o,
   output logic             last_o
);

   map_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [BLK_W-1:0] blk_q;
   logic             front_end, back_end, final_blk;

   assign front_end = (cnt_q == CNT_W'(HALF - 1));
   assign back_end  = (cnt_q == CNT_W'(SYMS - 1));
   assign final_blk = (blk_q == BLK_W'(BLOCKS - 1));
   assign accept_o  = start_i && (state_q == ST_IDLE);
   assign last_o    = (state_q == ST_BACK) && back_end && final_blk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         blk_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (accept_o) begin
                  state_q <= ST_PREP;
                  blk_q   <= '0;
               end
            end
            ST_PREP: begin
               cnt_q   <= '0;
               state_q <= ST_FRONT;
            end
            ST_FRONT: begin
               cnt_q <= cnt_q + 1'b1;
               if (front_end) state_q <= ST_BACK;
            end
            default: begin
               if (back_end) begin
                  cnt_q <= '0;
                  if (final_blk) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_PREP;
                     blk_q   <= blk_q + 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign state_o = state_q;
   assign cnt_o   = cnt_q;
   assign blk_o   = blk_q;

   // R5
   prep_to_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PREP) |=> (state_q == ST_FRONT) && (cnt_q == '0));

   // R4
   front_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FRONT) && front_end |=> (state_q == ST_BACK) && (cnt_q == CNT_W'(HALF)));

   // R6
   blk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (blk_q <= BLK_W'(BLOCKS - 1)));

   // R6
   blk_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BACK) && back_end && !final_blk |=> (blk_q == $past(blk_q) + 1'b1));

endmodule

// File: rtl/dcm_bit_gather.sv
module dcm_bit_gather #(
   parameter int HALF   = 50,
   localparam int BB    = 4 * HALF,
   localparam int GRP_W = $clog2(HALF),
   localparam int POS_W = $clog2(BB)
) (
   input  logic [BB-1:0]    blk_bits_i,
   input  logic [GRP_W-1:0] grp_i,
   output logic [3:0]       nib_o
);

   logic [POS_W-1:0] two_k, base;

   always_comb begin
      two_k = POS_W'(grp_i) << 1;
      base  = (grp_i < GRP_W'(HALF / 2)) ? two_k : two_k + POS_W'(HALF);
      nib_o = { blk_bits_i[base],
                blk_bits_i[base + POS_W'(1)],
                blk_bits_i[base + POS_W'(HALF)],
                blk_bits_i[base + POS_W'(HALF + 1)] };
   end

endmodule

// File: rtl/dcm_sym_map.sv
module dcm_sym_map
   import dcm_map_pkg::*;
#(
   parameter int MAP_STYLE = 0
) (
   input  logic [3:0] nib_i,
   output sym_t       lo_o,
   output sym_t       hi_o
);

   generate
      if (MAP_STYLE == 0) begin : g_table
         always_comb begin
            lo_o.re = lower_level(nib_i[3:2]);
            lo_o.im = lower_level(nib_i[1:0]);
            hi_o.re = upper_level(nib_i[3:2]);
            hi_o.im = upper_level(nib_i[1:0]);
         end
      end else begin : g_gates
         assign lo_o.re = {~nib_i[3], ~nib_i[3], nib_i[2], 1'b1};
         assign lo_o.im = {~nib_i[1], ~nib_i[1], nib_i[0], 1'b1};
         assign hi_o.re = {nib_i[2], nib_i[2], nib_i[3], 1'b1};
         assign hi_o.im = {nib_i[0], nib_i[0], nib_i[1], 1'b1};
      end
   endgenerate

endmodule

// File: rtl/dcm_half_buf.sv
module dcm_half_buf #(
   parameter int DEPTH = 50,
   parameter int WIDTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [AW-1:0]    waddr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [AW-1:0]    raddr_i,
   output logic [WIDTH-1:0] rdata_o
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];

   // R4
   waddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> (waddr_i <= AW'(DEPTH - 1)));

   // R4
   raddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raddr_i <= AW'(DEPTH - 1));

endmodule

// File: rtl/dcm_mapper.sv
module dcm_mapper
   import dcm_map_pkg::*;
#(
   parameter int HALF      = 50,
   parameter int BLOCKS    = 6,
   parameter int MAP_STYLE = 0,
   localparam int BB       = 4 * HALF,
   localparam int FB       = BLOCKS * BB,
   localparam int SYMS     = 2 * HALF,
   localparam int IDX_W    = $clog2(SYMS),
   localparam int GRP_W    = $clog2(HALF),
   localparam int BLK_W    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [FB-1:0]    frame_i,
   output logic             sym_valid_o,
   output logic [3:0]       sym_i_o,
   output logic [3:0]       sym_q_o,
   output logic [IDX_W-1:0] sym_idx_o,
   output logic             done_o
);

   generate
      if (HALF < 2 || (HALF % 2) != 0) begin : g_bad_half
         $error("HALF must be even and at least 2");
      end
      if (BLOCKS < 1) begin : g_bad_blocks
         $error("BLOCKS must be at least 1");
      end
      if (MAP_STYLE < 0 || MAP_STYLE > 1) begin : g_bad_style
         $error("MAP_STYLE must be 0 or 1");
      end
   endgenerate

   map_state_e       state;
   logic [IDX_W-1:0] cnt;
   logic [BLK_W-1:0] blk;
   logic             accept, last;
   logic [FB-1:0]    frame_q;
   logic [BB-1:0]    blk_bits;
   logic [GRP_W-1:0] grp, rd_addr;
   logic [3:0]       nib;
   sym_t             lo_sym, hi_sym, rd_sym;
   logic             in_front, in_back;

   dcm_map_ctrl #(.HALF(HALF), .BLOCKS(BLOCKS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .state_o  (state),
      .cnt_o    (cnt),
      .blk_o    (blk),
      .accept_o (accept),
      .last_o   (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      frame_q <= '0;
      else if (accept) frame_q <= frame_i;
   end

   assign in_front = (state == ST_FRONT);
   assign in_back  = (state == ST_BACK);
   assign blk_bits = frame_q[int'(blk) * BB +: BB];
   assign grp      = in_front ? GRP_W'(cnt) : '0;
   assign rd_addr  = in_back ? GRP_W'(cnt - IDX_W'(HALF)) : '0;

   dcm_bit_gather #(.HALF(HALF)) u_gather (
      .blk_bits_i (blk_bits),
      .grp_i      (grp),
      .nib_o      (nib)
   );

   dcm_sym_map #(.MAP_STYLE(MAP_STYLE)) u_map (
      .nib_i (nib),
      .lo_o  (lo_sym),
      .hi_o  (hi_sym)
   );

   dcm_half_buf #(.DEPTH(HALF), .WIDTH($bits(sym_t))) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (in_front),
      .waddr_i (grp),
      .wdata_i (hi_sym),
      .raddr_i (rd_addr),
      .rdata_o (rd_sym)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sym_valid_o <= 1'b0;
         sym_i_o     <= '0;
         sym_q_o     <= '0;
         sym_idx_o   <= '0;
         done_o      <= 1'b0;
      end else begin
         sym_valid_o <= in_front || in_back;
         done_o      <= last;
         if (in_front) begin
            sym_i_o   <= lo_sym.re;
            sym_q_o   <= lo_sym.im;
            sym_idx_o <= cnt;
         end else if (in_back) begin
            sym_i_o   <= rd_sym.re;
            sym_q_o   <= rd_sym.im;
            sym_idx_o <= cnt;
         end else begin
            sym_i_o   <= '0;
            sym_q_o   <= '0;
            sym_idx_o <= '0;
         end
      end
   end

   // R4
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o && (sym_idx_o != IDX_W'(SYMS - 1))
      |=> sym_valid_o && (sym_idx_o == $past(sym_idx_o) + 1'b1));

   // R5
   block_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o && (sym_idx_o == IDX_W'(SYMS - 1)) |=> !sym_valid_o);

   // R7
   done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> sym_valid_o && (sym_idx_o == IDX_W'(SYMS - 1)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(frame_q));

   // R2
   level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_o |-> sym_i_o[0] && (sym_i_o[3] == sym_i_o[2])
                   && sym_q_o[0] && (sym_q_o[3] == sym_q_o[2]));

   // R9
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_valid_o |-> (sym_i_o == '0) && (sym_q_o == '0) && (sym_idx_o == '0) && !done_o);

endmodule

// File: tb/dcm_mapper_tb.sv
module dcm_mapper_tb;

   localparam int HALF   = 50;
   localparam int BLOCKS = 6;
   localparam int BB     = 4 * HALF;
   localparam int FB     = BLOCKS * BB;
   localparam int SYMS   = 2 * HALF;
   localparam int IDX_W  = $clog2(SYMS);

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start_i;
   logic [FB-1:0]    frame_i;
   logic             v_a, v_b, d_a, d_b;
   logic [3:0]       i_a, q_a, i_b, q_b;
   logic [IDX_W-1:0] x_a, x_b;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   dcm_mapper #(.HALF(HALF), .BLOCKS(BLOCKS), .MAP_STYLE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
      .sym_valid_o(v_a), .sym_i_o(i_a), .sym_q_o(q_a), .sym_idx_o(x_a), .done_o(d_a));

   dcm_mapper #(.HALF(HALF), .BLOCKS(BLOCKS), .MAP_STYLE(1)) u_alt (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
      .sym_valid_o(v_b), .sym_i_o(i_b), .sym_q_o(q_b), .sym_idx_o(x_b), .done_o(d_b));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL R6 watchdog: actual %0d cycles expected below 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [3:0] lo_val(input logic [1:0] p);
      logic [3:0] r;
      case (p)
         2'd0: r = 4'hD;
         2'd1: r = 4'hF;
         2'd2: r = 4'h1;
         default: r = 4'h3;
      endcase
      return r;
   endfunction

   function automatic logic [3:0] hi_val(input logic [1:0] p);
      logic [3:0] r;
      case (p)
         2'd0: r = 4'h1;
         2'd1: r = 4'hD;
         2'd2: r = 4'h3;
         default: r = 4'hF;
      endcase
      return r;
   endfunction

   function automatic int grp_pos(input int k);
      return (k < HALF / 2) ? 2 * k : 2 * k + HALF;
   endfunction

   function automatic logic [7:0] exp_sym(input logic [FB-1:0] f, input int blk, input int s);
      int k, g, b;
      logic [3:0] v;
      k = s % HALF;
      g = grp_pos(k);
      b = blk * BB;
      v = {f[b + g], f[b + g + 1], f[b + g + HALF], f[b + g + HALF + 1]};
      if (s < HALF) return {lo_val(v[3:2]), lo_val(v[1:0])};
      return {hi_val(v[3:2]), hi_val(v[1:0])};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_quiet(input string req);
      check(v_a == 1'b0, {req, " valid low"}, v_a, 0);
      check({i_a, q_a, x_a, d_a} == '0, {req, " outputs zero"}, {i_a, q_a, x_a, d_a}, 0);
   endtask

   task automatic run_frame(input logic [FB-1:0] f, input bit disturb);
      @(negedge clk);
      frame_i = f;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check_quiet("R5 latency first cycle");
      @(negedge clk);
      check_quiet("R5 latency second cycle");
      @(negedge clk);
      for (int b = 0; b < BLOCKS; b++) begin
         for (int s = 0; s < SYMS; s++) begin
            logic [7:0] e;
            if (disturb && b == 2 && s == 10) begin
               start_i = 1'b1;
               frame_i = ~f;
            end else if (disturb && b == 2 && s == 11) begin
               start_i = 1'b0;
            end
            e = exp_sym(f, b, s);
            check(v_a == 1'b1, "R4 valid held", v_a, 1);
            check(x_a == IDX_W'(s), "R4 index order", x_a, s);
            if (s < HALF)
               check({i_a, q_a} == e, "R1 R2 R6 R8 lower symbol", {i_a, q_a}, e);
            else
               check({i_a, q_a} == e, "R1 R3 R6 R8 upper symbol", {i_a, q_a}, e);
            check({v_b, i_b, q_b, x_b} == {v_a, i_a, q_a, x_a}, "R2 R3 variant agreement",
                  {v_b, i_b, q_b, x_b}, {v_a, i_a, q_a, x_a});
            check(d_a == (b == BLOCKS - 1 && s == SYMS - 1), "R7 done position",
                  d_a, (b == BLOCKS - 1 && s == SYMS - 1));
            @(negedge clk);
         end
         check_quiet("R5 R9 gap after block");
         if (b != BLOCKS - 1) @(negedge clk);
      end
      check(d_a == 1'b0, "R7 done single cycle", d_a, 0);
      for (int w = 0; w < 3; w++) begin
         @(negedge clk);
         check_quiet("R6 R8 idle after frame");
      end
   endtask

   initial begin
      logic [FB-1:0] f;
      void'($urandom(32'd1937));
      rst_n   = 1'b0;
      start_i = 1'b0;
      frame_i = '0;
      repeat (3) @(negedge clk);
      check_quiet("R9 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_quiet("R9 after reset");

      run_frame('0, 1'b0);
      run_frame('1, 1'b0);

      // every nibble value appears in each block
      f = '0;
      for (int b = 0; b < BLOCKS; b++) begin
         for (int k = 0; k < HALF; k++) begin
            logic [3:0] v;
            int g;
            v = 4'((k + b) % 16);
            g = b * BB + grp_pos(k);
            f[g]            = v[3];
            f[g + 1]        = v[2];
            f[g + HALF]     = v[1];
            f[g + HALF + 1] = v[0];
         end
      end
      run_frame(f, 1'b0);

      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < FB; i++) f[i] = 1'($urandom);
         run_frame(f, r == 1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule